// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block puts a bank of 64-bit registers behind a 32-bit memory-mapped port. The bank holds plain read/write registers followed by free-running event counters (request counts and byte counts, for example). Software sees every entry as a pair of 32-bit words. The even word address of a pair carries bits 63..32 and the odd word address carries bits 31..0.

A write to the even word is only held in a shared staging register. The next write to an odd word commits the staged half and the new half to the entry in a single cycle. Reads use a matching hold: reading the even word of an entry captures that entry's low half, so a later read of the odd word returns a value from the same instant. This stays true while a counter keeps advancing between the two bus cycles. Each counter has an increment strobe and a step size, so one counter can count events while another accumulates byte totals.

Top module: `split64_bridge`

## Requirements
- R1: After reset every entry reads 0, the staged half is 0, no read response is pending, and `req_ready` is high.
- R2: Word address 2k+0 reads bits 63..32 of entry k, and word address 2k+1 reads bits 31..0. Entries 0..NUM_REGS-1 are plain registers. Entries NUM_REGS..NUM_REGS+NUM_CNT-1 are counters 0..NUM_CNT-1.
- R3: A write to an even word address changes no entry. It only replaces the staged upper half.
- R4: A write to the odd word of an in-range entry sets that entry to {staged half, write data} in one cycle. Any odd-word write, in range or not, then clears the staged half to 0. A lone odd-word write therefore commits zeros in bits 63..32.
- R5: `req_ready` is always high. `rsp_valid` is high for exactly the cycle after each accepted read and low otherwise, and `rsp_rdata` carries the read data in that cycle.
- R6: A read of an even word captures the entry's bits 31..0 at that moment. The next odd-word read of the same entry returns that captured value, even if the entry has changed since.
- R7: An odd-word read returns the live bits 31..0 when the capture is absent, already consumed, or belongs to another entry. Any odd-word read consumes the capture.
- R8: In each cycle that counter c has `cnt_inc[c]` high, it adds `cnt_step[c*STEP_W +: STEP_W]` (zero-extended).
- R9: When an odd-word write commits to a counter in the same cycle as its increment, the written value wins and the increment is lost.
- R10: Counters wrap modulo 2^64 and do not saturate.
- R11: Word addresses whose entry index is NUM_REGS+NUM_CNT or higher read as 0, and writes to them change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: entry index above bit 0, bit 0 selects the half |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| cnt_inc | input | NUM_CNT | Per-counter increment strobe |
| cnt_step | input | NUM_CNT*STEP_W | Per-counter increment amount, packed |

## Verification
On every cycle, the assertions check the timing of the read response, that even-word writes leave the plain registers untouched, that odd-word writes commit the staged half together with the data and then clear the stage, and that each counter advances by exactly its step or holds. Several behaviours only the directed scenarios can show, because they depend on a chosen order of bus cycles and known values. These are the coherent two-cycle read of a counter moving across a 32-bit carry, a live read when the capture belongs to another entry, write-over-increment priority, the 2^64 wrap, and the out-of-range window.

// File: rtl/split64_bridge.sv
module split64_bridge #(
  parameter int NUM_REGS = 4,
  parameter int NUM_CNT  = 7,
  parameter int STEP_W   = 16,
  localparam int NUM_ENT = NUM_REGS + NUM_CNT,
  localparam int IDX_W   = $clog2(NUM_ENT),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  input  logic [NUM_CNT-1:0]        cnt_inc,
  input  logic [NUM_CNT*STEP_W-1:0] cnt_step
);

  logic [NUM_ENT-1:0][63:0] ent_q;
  logic [31:0]              stage_q;
  logic [31:0]              snap_q;
  logic                     snap_vld_q;
  logic [IDX_W-1:0]         snap_idx_q;

  wire             rd_en   = req_valid & ~req_write;
  wire             wr_en   = req_valid &  req_write;
  wire [IDX_W-1:0] idx     = req_addr[ADDR_W-1:1];
  wire             lo_half = req_addr[0];
  wire             in_rng  = {1'b0, idx} < (IDX_W+1)'(NUM_ENT);
  wire             commit  = wr_en & lo_half & in_rng;

  logic [63:0] cur;
  always_comb begin
    cur = '0;
    for (int e = 0; e < NUM_ENT; e++)
      if (in_rng && idx == IDX_W'(e)) cur = ent_q[e];
  end

  wire        snap_hit = snap_vld_q && snap_idx_q == idx;
  wire [31:0] rd_word  = !lo_half ? cur[63:32] : (snap_hit ? snap_q : cur[31:0]);

  assign req_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q    <= '0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
      snap_idx_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_word;
      if (wr_en) stage_q <= lo_half ? 32'h0 : req_wdata;
      if (rd_en && !lo_half) begin
        snap_q     <= cur[31:0];
        snap_vld_q <= 1'b1;
        snap_idx_q <= idx;
      end else if (rd_en && lo_half) begin
        snap_vld_q <= 1'b0;
      end
    end
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    wire hit = commit && idx == IDX_W'(e);
    if (e < NUM_REGS) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)   ent_q[e] <= '0;
        else if (hit) ent_q[e] <= {stage_q, req_wdata};
      end
    end else begin : g_cnt
      localparam int C = e - NUM_REGS;
      wire [63:0] step = 64'(cnt_step[C*STEP_W +: STEP_W]);
      always_ff @(posedge clk) begin
        if (!rst_n)          ent_q[e] <= '0;
        else if (hit)        ent_q[e] <= {stage_q, req_wdata};
        else if (cnt_inc[C]) ent_q[e] <= ent_q[e] + step;
      end
    end
  end

endmodule

// File: rtl/split64_bridge_chk.sv
module split64_bridge_chk #(
  parameter int NUM_REGS = 4,
  parameter int NUM_CNT  = 7,
  parameter int STEP_W   = 16,
  localparam int NUM_ENT = NUM_REGS + NUM_CNT,
  localparam int IDX_W   = $clog2(NUM_ENT),
  localparam int ADDR_W  = IDX_W + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic [31:0]               req_wdata,
  input logic                      rsp_valid,
  input logic [31:0]               stage_q,
  input logic [NUM_ENT-1:0][63:0]  ent_q,
  input logic [NUM_CNT-1:0]        cnt_inc,
  input logic [NUM_CNT*STEP_W-1:0] cnt_step
);
  wire             rd     = req_valid && !req_write;
  wire             wr_hi  = req_valid && req_write && !req_addr[0];
  wire             wr_lo  = req_valid && req_write && req_addr[0];
  wire [IDX_W-1:0] widx   = req_addr[ADDR_W-1:1];
  wire             in_rng = {1'b0, widx} < (IDX_W+1)'(NUM_ENT);
  logic [NUM_REGS-1:0][63:0] plain;
  always_comb for (int i = 0; i < NUM_REGS; i++) plain[i] = ent_q[i];

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) req_ready); // R5
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rsp_valid); // R5
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> !rsp_valid); // R5
  AST_HI_WRITE_STAGES: assert property (@(posedge clk) disable iff (!rst_n) wr_hi |=> plain == $past(plain)); // R3
  AST_LO_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && in_rng) |=> ent_q[$past(widx)] == {$past(stage_q), $past(req_wdata)}); // R4
  AST_STAGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_lo |=> stage_q == 32'h0); // R4

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_c
    wire hit = wr_lo && in_rng && widx == IDX_W'(NUM_REGS + c);
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc[c] && !hit) |=> ent_q[NUM_REGS+c] ==
        $past(ent_q[NUM_REGS+c]) + 64'($past(cnt_step[c*STEP_W +: STEP_W]))); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_inc[c] && !wr_lo) |=> $stable(ent_q[NUM_REGS+c])); // R8
  end
endmodule

bind split64_bridge split64_bridge_chk #(.NUM_REGS(NUM_REGS), .NUM_CNT(NUM_CNT), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .stage_q(stage_q), .ent_q(ent_q),
  .cnt_inc(cnt_inc), .cnt_step(cnt_step));

// File: tb/tb_split64_bridge.sv
module tb_split64_bridge;
  localparam int NR = 4, NC = 7, SW = 16, AW = 5;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_valid, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic [NC-1:0] cnt_inc = '0;
  logic [NC*SW-1:0] cnt_step = '0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  split64_bridge #(.NUM_REGS(NR), .NUM_CNT(NC), .STEP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cnt_inc(cnt_inc), .cnt_step(cnt_step));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int waddr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(waddr); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int waddr, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(waddr);
    @(negedge clk);
    req_valid = 0;
    check("R5 rsp_valid", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic wr64(input int e, input logic [63:0] v);
    wr(2*e, v[63:32]); wr(2*e+1, v[31:0]);
  endtask

  task automatic rd64(input int e, output logic [63:0] v);
    logic [31:0] h, l;
    rd(2*e, h); rd(2*e+1, l); v = {h, l};
  endtask

  task automatic t_reset;
    logic [63:0] v;
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    rd64(2, v); check("R1 reg reset", v, 64'd0);
    rd64(NR+3, v); check("R1 cnt reset", v, 64'd0);
    wr(3, 32'h0000_0011); rd64(1, v); check("R1 stage reset", v, 64'h11);
  endtask

  task automatic t_map;
    logic [31:0] w;
    wr64(0, 64'hA1B2C3D4_E5F60718);
    rd(0, w); check("R2 even word upper", 64'(w), 64'hA1B2C3D4);
    rd(1, w); check("R2 odd word lower", 64'(w), 64'hE5F60718);
    @(negedge clk);
    check("R5 rsp drops", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_stage;
    logic [63:0] v;
    wr64(2, 64'h11112222_33334444);
    wr(4, 32'hDEADBEEF);
    rd64(2, v); check("R3 upper write staged only", v, 64'h11112222_33334444);
    wr(5, 32'h55556666);
    rd64(2, v); check("R4 commit with staged half", v, 64'hDEADBEEF_55556666);
    wr(5, 32'h77778888);
    rd64(2, v); check("R4 lone lower write zero upper", v, 64'h00000000_77778888);
  endtask

  task automatic t_snapshot;
    logic [31:0] h, l;
    logic [63:0] v;
    wr64(NR+0, 64'h00000005_FFFFFFFF);
    @(negedge clk);
    cnt_inc[0] = 1; cnt_step[0 +: SW] = 16'd1;
    req_valid = 1; req_write = 0; req_addr = AW'(2*NR);
    @(negedge clk);
    h = rsp_rdata;
    req_addr = AW'(2*NR+1);
    @(negedge clk);
    l = rsp_rdata;
    req_valid = 0; cnt_inc = '0;
    check("R6 coherent upper", 64'(h), 64'h5);
    check("R6 latched lower", 64'(l), 64'hFFFFFFFF);
    rd64(NR+0, v); check("R8 counted twice", v, 64'h00000006_00000001);
  endtask

  task automatic t_live;
    logic [31:0] w;
    wr64(NR+1, 64'h0);
    wr64(1, 64'h12345678_9ABCDEF0);
    rd(2, w);
    @(negedge clk); cnt_inc[1] = 1; cnt_step[SW +: SW] = 16'd7;
    repeat (3) @(negedge clk);
    cnt_inc = '0;
    rd(2*(NR+1)+1, w); check("R7 capture of other entry ignored", 64'(w), 64'd21);
    rd(2, w); rd(3, w); rd(3, w); check("R7 consumed capture live", 64'(w), 64'h9ABCDEF0);
  endtask

  task automatic t_priority;
    logic [63:0] v;
    wr(2*(NR+2), 32'hCAFE0000);
    @(negedge clk);
    cnt_inc[2] = 1; cnt_step[2*SW +: SW] = 16'd100;
    req_valid = 1; req_write = 1; req_addr = AW'(2*(NR+2)+1); req_wdata = 32'h0000BABE;
    @(negedge clk);
    req_valid = 0; req_write = 0; cnt_inc = '0;
    rd64(NR+2, v); check("R9 write beats increment", v, 64'hCAFE0000_0000BABE);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    wr64(NR+6, 64'hFFFFFFFF_FFFFFFFF);
    @(negedge clk); cnt_inc[6] = 1; cnt_step[6*SW +: SW] = 16'd3;
    @(negedge clk); cnt_inc = '0;
    rd64(NR+6, v); check("R10 wrap", v, 64'h2);
    wr64(NR+5, 64'h0);
    @(negedge clk); cnt_inc[5] = 1; cnt_step[5*SW +: SW] = 16'hFFFF;
    @(negedge clk); cnt_inc = '0;
    rd64(NR+5, v); check("R8 full step", v, 64'hFFFF);
  endtask

  task automatic t_range;
    logic [63:0] v;
    wr64(12, 64'h01020304_05060708);
    rd64(12, v); check("R11 out of range reads 0", v, 64'd0);
    rd64(3, v); check("R11 no alias write", v, 64'd0);
    wr(6, 32'hFFFF0000); wr(31, 32'h1); wr(7, 32'h2);
    rd64(3, v); check("R4 stage cleared by out-of-range lower write", v, 64'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_map; t_stage; t_snapshot; t_live; t_priority; t_wrap; t_range;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule